// File: doc/BRIEF.md
# Multi-Channel Pulse-Width Modulator with Staged Settings

This block drives a bank of independent pulse-width modulated outputs from one clock. Each channel divides the clock by a programmable prescale factor, counts the resulting steps up to a programmable modulus, and holds its output high for a programmable number of those steps at the start of each period. Software reaches the block through a plain 32-bit register port. A write is accepted on any clock edge where the write strobe is high. Read data is a combinational function of the address.

Prescale and modulus writes only stage new values. A write to the duty register is the commit. If the channel is running, the committed set takes effect at the next period boundary, so no period ever mixes old and new settings. If the channel is stopped, the commit applies at once. Clearing the enable bit stops a channel in the same cycle, even mid-period.

Each channel is a three-state machine:
- `ST_OFF`: stopped, output low.
- `ST_RUN`: running, nothing staged.
- `ST_PEND`: running with a committed set waiting for the period boundary.

The transitions are:
- *start* (`ST_OFF`→`ST_RUN`): enable written as 1.
- *stage* (`ST_RUN`→`ST_PEND`): duty written.
- *apply* (`ST_PEND`→`ST_RUN`): end of period.
- *stop* (`ST_RUN` or `ST_PEND`→`ST_OFF`): enable written as 0.

Top module: `pwm_bank`

## Requirements
- R1: After reset every output is low and every register of every channel reads zero.
- R2: Channel k occupies addresses k*32 to k*32+31, with these registers:
  - offset 0x00: prescale, bits 7:0.
  - offset 0x04: modulus, bits 7:0.
  - offset 0x08: duty, bits 15:0.
  - offset 0x18: enable, bit 0.

  Each register reads back the last value written, and other bits read zero. Other offsets, including unaligned ones, read zero and ignore writes. The enable register reads 1 while the channel runs.
- R3: A running channel with prescale P, modulus M and duty D repeats a period of (P+1)*M cycles. The output is high for the first (P+1)*D cycles of each period. Writing enable as 1 to a stopped channel starts a fresh period on the accepting clock edge, with the output high in the following cycle if D is nonzero. Writing enable as 1 to a running channel has no effect.
- R4: Writes to prescale or modulus do not change the output of a running channel until a duty write follows.
- R5: A duty write to a running channel lets the period in progress finish with the old settings. The new prescale, modulus and duty start together with the next period.
- R6: Writing enable as 0 drives the output low from the cycle after the accepting edge, without waiting for the period end. A later enable starts a fresh period.
- R7: A duty value greater than or equal to the modulus gives a constant-high output. A duty of 0 gives a constant-low output.
- R8: Channels are independent: writes to one channel never alter the output or running state of another.
- R9: A duty write to a stopped channel commits the staged prescale, modulus and the new duty at once, so the next enable uses them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock and count source |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe, one write per high cycle |
| reg_addr | input | 7 | Byte address: channel in bits 6:5, register offset in bits 4:0 |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| pwm_out | output | 4 | One active-high output per channel |

## Verification
The assertions assume `reg_addr` and `reg_wdata` hold known values whenever `reg_wr` is high, and that at most one write occurs per cycle. This is the only way the port can express an access anyway. The stimulus changes inputs only on falling clock edges and raises the strobe for exactly one rising edge per write, so every decoded write strobe seen by the checker matches one bench write. Period measurements synchronise on an observed rising output. Mid-period writes are issued at a known phase relative to that rise.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

    localparam int PRE_W    = 8;
    localparam int MOD_W    = 8;
    localparam int DUTY_W   = 16;
    localparam int DATA_W   = 32;
    localparam int CH_SHIFT = 5;

    localparam logic [CH_SHIFT-1:0] OFS_PRE  = 5'h00;
    localparam logic [CH_SHIFT-1:0] OFS_MOD  = 5'h04;
    localparam logic [CH_SHIFT-1:0] OFS_DUTY = 5'h08;
    localparam logic [CH_SHIFT-1:0] OFS_EN   = 5'h18;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_RUN  = 2'd1,
        ST_PEND = 2'd2
    } chan_state_e;

endpackage

// File: rtl/pwm_regdec.sv
module pwm_regdec
    import pwm_bank_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int AW     = 7
) (
    input  logic                           reg_wr,
    input  logic [AW-1:0]                  reg_addr,
    output logic [NUM_CH-1:0]              wr_pre,
    output logic [NUM_CH-1:0]              wr_mod,
    output logic [NUM_CH-1:0]              wr_duty,
    output logic [NUM_CH-1:0]              wr_en,
    input  logic [NUM_CH-1:0][PRE_W-1:0]   rd_pre,
    input  logic [NUM_CH-1:0][MOD_W-1:0]   rd_mod,
    input  logic [NUM_CH-1:0][DUTY_W-1:0]  rd_duty,
    input  logic [NUM_CH-1:0]              rd_en,
    output logic [DATA_W-1:0]              reg_rdata
);

    localparam int IDX_W = AW - CH_SHIFT;

    logic [IDX_W-1:0]    ch_idx;
    logic [CH_SHIFT-1:0] ofs;

    assign ch_idx = reg_addr[AW-1:CH_SHIFT];
    assign ofs    = reg_addr[CH_SHIFT-1:0];

    for (genvar k = 0; k < NUM_CH; k++) begin : g_dec
        logic hit;
        assign hit        = reg_wr && (ch_idx == IDX_W'(k));
        assign wr_pre[k]  = hit && (ofs == OFS_PRE);
        assign wr_mod[k]  = hit && (ofs == OFS_MOD);
        assign wr_duty[k] = hit && (ofs == OFS_DUTY);
        assign wr_en[k]   = hit && (ofs == OFS_EN);
    end

    always_comb begin
        reg_rdata = '0;
        for (int k = 0; k < NUM_CH; k++) begin
            if (ch_idx == IDX_W'(k)) begin
                case (ofs)
                    OFS_PRE:  reg_rdata = DATA_W'(rd_pre[k]);
                    OFS_MOD:  reg_rdata = DATA_W'(rd_mod[k]);
                    OFS_DUTY: reg_rdata = DATA_W'(rd_duty[k]);
                    OFS_EN:   reg_rdata = DATA_W'(rd_en[k]);
                    default:  reg_rdata = '0;
                endcase
            end
        end
    end

endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
    import pwm_bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_pre,
    input  logic              wr_mod,
    input  logic              wr_duty,
    input  logic              wr_en,
    input  logic [PRE_W-1:0]  wdata_pre,
    input  logic [MOD_W-1:0]  wdata_mod,
    input  logic [DUTY_W-1:0] wdata_duty,
    input  logic              wdata_en,
    output logic [PRE_W-1:0]  rd_pre,
    output logic [MOD_W-1:0]  rd_mod,
    output logic [DUTY_W-1:0] rd_duty,
    output logic              rd_en,
    output logic              pwm,
    output logic              running,
    output logic              at_start
);

    chan_state_e state_q, state_d;

    // staged (software-visible) settings
    logic [PRE_W-1:0]  stg_pre;
    logic [MOD_W-1:0]  stg_mod;
    logic [DUTY_W-1:0] stg_duty;

    // settings in force on the output
    logic [PRE_W-1:0]  act_pre;
    logic [MOD_W-1:0]  act_mod;
    logic [DUTY_W-1:0] act_duty;

    logic [PRE_W-1:0]  pre_cnt;
    logic [MOD_W-1:0]  mod_cnt;
    logic              tick, last_step, period_end;

    assign tick       = (pre_cnt == act_pre);
    assign last_step  = ({1'b0, mod_cnt} + (MOD_W+1)'(1)) >= {1'b0, act_mod};
    assign period_end = (state_q != ST_OFF) && tick && last_step;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (wr_en && wdata_en) state_d = ST_RUN;          // start
            end
            ST_RUN: begin
                if (wr_en && !wdata_en) state_d = ST_OFF;         // stop
                else if (wr_duty)       state_d = ST_PEND;        // stage
            end
            ST_PEND: begin
                if (wr_en && !wdata_en) state_d = ST_OFF;         // stop
                else if (period_end && !wr_duty) state_d = ST_RUN; // apply
            end
            default: state_d = ST_OFF;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // staged register file
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_pre  <= '0;
            stg_mod  <= '0;
            stg_duty <= '0;
        end else begin
            if (wr_pre)  stg_pre  <= wdata_pre;
            if (wr_mod)  stg_mod  <= wdata_mod;
            if (wr_duty) stg_duty <= wdata_duty;
        end
    end

    // outputs: active settings and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_pre  <= '0;
            act_mod  <= '0;
            act_duty <= '0;
            pre_cnt  <= '0;
            mod_cnt  <= '0;
        end else begin
            if (state_q == ST_OFF && wr_duty) begin
                act_pre  <= stg_pre;
                act_mod  <= stg_mod;
                act_duty <= wdata_duty;
            end else if (state_q == ST_PEND && period_end) begin
                act_pre  <= stg_pre;
                act_mod  <= stg_mod;
                act_duty <= stg_duty;
            end

            if (state_q == ST_OFF || state_d == ST_OFF || period_end) begin
                pre_cnt <= '0;
                mod_cnt <= '0;
            end else if (tick) begin
                pre_cnt <= '0;
                mod_cnt <= mod_cnt + MOD_W'(1);
            end else begin
                pre_cnt <= pre_cnt + PRE_W'(1);
            end
        end
    end

    assign running  = (state_q != ST_OFF);
    assign at_start = running && (pre_cnt == '0) && (mod_cnt == '0);
    assign pwm      = running && (DUTY_W'(mod_cnt) < act_duty);

    assign rd_pre  = stg_pre;
    assign rd_mod  = stg_mod;
    assign rd_duty = stg_duty;
    assign rd_en   = running;

endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
    import pwm_bank_pkg::*;
#(
    parameter  int NUM_CH = 4,
    localparam int IDX_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int AW     = CH_SHIFT + IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [AW-1:0]     reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [NUM_CH-1:0] pwm_out
);

    logic [NUM_CH-1:0]             wr_pre, wr_mod, wr_duty, wr_en;
    logic [NUM_CH-1:0][PRE_W-1:0]  rd_pre;
    logic [NUM_CH-1:0][MOD_W-1:0]  rd_mod;
    logic [NUM_CH-1:0][DUTY_W-1:0] rd_duty;
    logic [NUM_CH-1:0]             rd_en;
    logic [NUM_CH-1:0]             run_vec, start_vec;
    logic                          wdata_unused_hi;

    assign wdata_unused_hi = ^reg_wdata[DATA_W-1:DUTY_W];

    pwm_regdec #(.NUM_CH(NUM_CH), .AW(AW)) u_dec (
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .wr_pre    (wr_pre),
        .wr_mod    (wr_mod),
        .wr_duty   (wr_duty),
        .wr_en     (wr_en),
        .rd_pre    (rd_pre),
        .rd_mod    (rd_mod),
        .rd_duty   (rd_duty),
        .rd_en     (rd_en),
        .reg_rdata (reg_rdata)
    );

    for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
        pwm_chan u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_pre     (wr_pre[k]),
            .wr_mod     (wr_mod[k]),
            .wr_duty    (wr_duty[k]),
            .wr_en      (wr_en[k]),
            .wdata_pre  (reg_wdata[PRE_W-1:0]),
            .wdata_mod  (reg_wdata[MOD_W-1:0]),
            .wdata_duty (reg_wdata[DUTY_W-1:0]),
            .wdata_en   (reg_wdata[0]),
            .rd_pre     (rd_pre[k]),
            .rd_mod     (rd_mod[k]),
            .rd_duty    (rd_duty[k]),
            .rd_en      (rd_en[k]),
            .pwm        (pwm_out[k]),
            .running    (run_vec[k]),
            .at_start   (start_vec[k])
        );
    end

endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk
    import pwm_bank_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int AW     = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [AW-1:0]     reg_addr,
    input logic              wbit0,
    input logic [NUM_CH-1:0] pwm_out,
    input logic [NUM_CH-1:0] run_vec,
    input logic [NUM_CH-1:0] start_vec
);

    localparam int IDX_W = AW - CH_SHIFT;

    for (genvar k = 0; k < NUM_CH; k++) begin : g_prop
        logic en_wr_k, en_wr_other;
        assign en_wr_k = reg_wr && reg_addr[CH_SHIFT-1:0] == OFS_EN
                         && reg_addr[AW-1:CH_SHIFT] == IDX_W'(k);
        assign en_wr_other = reg_wr && reg_addr[CH_SHIFT-1:0] == OFS_EN
                             && reg_addr[AW-1:CH_SHIFT] != IDX_W'(k);

        // R6: clearing enable stops the channel at once
        a_r6_stop_now: assert property (@(posedge clk) disable iff (!rst_n)
            en_wr_k && !wbit0 |=> !pwm_out[k] && !run_vec[k]);

        // R3: a stopped channel starts with a fresh period
        a_r3_fresh_start: assert property (@(posedge clk) disable iff (!rst_n)
            en_wr_k && wbit0 && !run_vec[k] |=> run_vec[k] && start_vec[k]);

        // R3 / R5: the output only rises at a period start
        a_r3_rise_at_start: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pwm_out[k]) |-> start_vec[k]);

        // R8: enable writes to another channel leave this one running
        a_r8_no_cross_stop: assert property (@(posedge clk) disable iff (!rst_n)
            en_wr_other && run_vec[k] |=> run_vec[k]);
    end

endmodule

bind pwm_bank pwm_bank_chk #(.NUM_CH(NUM_CH), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .wbit0     (reg_wdata[0]),
    .pwm_out   (pwm_out),
    .run_vec   (run_vec),
    .start_vec (start_vec)
);

// File: tb/pwm_bank_tb.sv
module pwm_bank_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 7;

    typedef struct packed {
        logic [7:0]  pre;
        logic [7:0]  mod;
        logic [15:0] duty;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{pre: 8'd0, mod: 8'd10,  duty: 16'd3},
        '{pre: 8'd1, mod: 8'd8,   duty: 16'd5},
        '{pre: 8'd2, mod: 8'd5,   duty: 16'd5},
        '{pre: 8'd0, mod: 8'd4,   duty: 16'd9},
        '{pre: 8'd3, mod: 8'd6,   duty: 16'd0},
        '{pre: 8'd0, mod: 8'd255, duty: 16'd128},
        '{pre: 8'd7, mod: 8'd3,   duty: 16'd1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [6:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [3:0]  pwm_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_bank u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .pwm_out   (pwm_out)
    );

    function automatic logic [6:0] ad(int ch, int ofs);
        return 7'(ch * 32 + ofs);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    task automatic wr(logic [6:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [6:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    // waits for an observed rise, then counts highs and cycles until the next rise
    task automatic measure(int ch, output int hi, output int per);
        logic prev, cur;
        prev = pwm_out[ch];
        forever begin
            @(negedge clk); cur = pwm_out[ch];
            if (!prev && cur) break;
            prev = cur;
        end
        hi = 1; per = 1; prev = 1'b1;
        forever begin
            @(negedge clk); cur = pwm_out[ch];
            if (!prev && cur) break;
            per++; hi += int'(cur); prev = cur;
        end
    endtask

    task automatic wait_rise(int ch);
        logic prev, cur;
        prev = pwm_out[ch];
        forever begin
            @(negedge clk); cur = pwm_out[ch];
            if (!prev && cur) break;
            prev = cur;
        end
    endtask

    task automatic setup(int ch, int p, int m, int d);
        wr(ad(ch, 'h18), 32'd0);
        wr(ad(ch, 'h00), 32'(p));
        wr(ad(ch, 'h04), 32'(m));
        wr(ad(ch, 'h08), 32'(d));
        wr(ad(ch, 'h18), 32'd1);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        if (!done) $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic [31:0] d;
        int hi, per, lows;
        logic prev, cur;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check("R1 outputs", 32'(pwm_out), 32'd0);
        for (int ch = 0; ch < 4; ch++) begin
            rd(ad(ch, 'h00), d); check("R1 prescale", d, 0);
            rd(ad(ch, 'h04), d); check("R1 modulus", d, 0);
            rd(ad(ch, 'h08), d); check("R1 duty", d, 0);
            rd(ad(ch, 'h18), d); check("R1 enable", d, 0);
        end

        // R2: readback widths and unmapped offsets
        wr(ad(2, 'h00), 32'hFFFF_FFFF); rd(ad(2, 'h00), d); check("R2 prescale width", d, 32'hFF);
        wr(ad(2, 'h04), 32'h0000_01A5); rd(ad(2, 'h04), d); check("R2 modulus width", d, 32'hA5);
        wr(ad(2, 'h08), 32'h0001_2345); rd(ad(2, 'h08), d); check("R2 duty width", d, 32'h2345);
        wr(ad(2, 'h0C), 32'hFFFF_FFFF); rd(ad(2, 'h0C), d); check("R2 unmapped", d, 0);
        wr(ad(2, 'h01), 32'h0000_0077); rd(ad(2, 'h00), d); check("R2 unaligned ignored", d, 32'hFF);
        rd(ad(1, 'h00), d); check("R2 other channel", d, 0);
        wr(ad(2, 'h18), 32'hFFFF_FFFE); rd(ad(2, 'h18), d); check("R2 enable bit0 only", d, 0);
        check("R2 no output", 32'(pwm_out), 0);

        // R3 / R7 / R9: table of configurations, committed while stopped
        for (int i = 0; i < NV; i++) begin
            int ch, p, m, du, win, exp_hi;
            ch = i % 4; p = int'(VECS[i].pre); m = int'(VECS[i].mod); du = int'(VECS[i].duty);
            win = (p + 1) * m;
            exp_hi = (p + 1) * ((du < m) ? du : m);
            setup(ch, p, m, du);
            hi = 0;
            for (int j = 0; j < win; j++) begin
                hi += int'(pwm_out[ch]);
                @(negedge clk);
            end
            check("R3 R7 R9 high cycles in first period", 32'(hi), 32'(exp_hi));
            check("R3 R7 next period start level", 32'(pwm_out[ch]), 32'(du != 0));
            wr(ad(ch, 'h18), 32'd0);
        end

        // R4: staged prescale/modulus do not disturb a running channel
        setup(1, 0, 10, 3);
        wr(ad(1, 'h00), 32'd1);
        wr(ad(1, 'h04), 32'd4);
        measure(1, hi, per);
        check("R4 period unchanged", 32'(per), 32'd10);
        check("R4 high unchanged", 32'(hi), 32'd3);

        // R5: duty write mid-period applies at the boundary
        wait_rise(1);
        reg_wr = 1'b1; reg_addr = ad(1, 'h08); reg_wdata = 32'd1;
        hi = 1; per = 1; prev = 1'b1;
        forever begin
            @(negedge clk); reg_wr = 1'b0; cur = pwm_out[1];
            if (!prev && cur) break;
            per++; hi += int'(cur); prev = cur;
        end
        check("R5 running period completes old", 32'(per), 32'd10);
        check("R5 running period old high", 32'(hi), 32'd3);
        measure(1, hi, per);
        check("R5 new period length", 32'(per), 32'd8);
        check("R5 new high time", 32'(hi), 32'd2);
        wr(ad(1, 'h18), 32'd0);

        // R6: immediate stop, then a fresh period
        setup(0, 0, 10, 6);
        wait_rise(0);
        reg_wr = 1'b1; reg_addr = ad(0, 'h18); reg_wdata = 32'd0;
        @(negedge clk); reg_wr = 1'b0;
        check("R6 low right after stop", 32'(pwm_out[0]), 0);
        lows = 0;
        for (int j = 0; j < 20; j++) begin
            lows += int'(!pwm_out[0]);
            @(negedge clk);
        end
        check("R6 stays low while stopped", 32'(lows), 32'd20);
        wr(ad(0, 'h18), 32'd1);
        hi = 0;
        for (int j = 0; j < 10; j++) begin
            hi += int'(pwm_out[0]);
            @(negedge clk);
        end
        check("R6 fresh period high time", 32'(hi), 32'd6);
        wr(ad(0, 'h18), 32'd1);
        measure(0, hi, per);
        check("R3 enable rewrite does not restart", 32'(per), 32'd10);
        wr(ad(0, 'h18), 32'd0);

        // R8: two channels side by side
        setup(2, 1, 6, 2);
        setup(3, 0, 7, 5);
        measure(2, hi, per);
        check("R8 ch2 period", 32'(per), 32'd12);
        check("R8 ch2 high", 32'(hi), 32'd4);
        measure(3, hi, per);
        check("R8 ch3 period", 32'(per), 32'd7);
        check("R8 ch3 high", 32'(hi), 32'd5);
        wr(ad(2, 'h18), 32'd0);
        wr(ad(2, 'h08), 32'd3);
        measure(3, hi, per);
        check("R8 ch3 survives ch2 writes", 32'(per), 32'd7);
        check("R8 ch3 high after ch2 writes", 32'(hi), 32'd5);
        check("R8 ch2 stopped low", 32'(pwm_out[2]), 0);
        rd(ad(3, 'h18), d); check("R8 ch3 still enabled", d, 1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule